// File: doc/BRIEF.md
# Parallel Write Strobe Engine

This block drives an 8080-style parallel write bus. The host hands over one byte at a time through a valid/ready port. Each byte lands in a single-entry staging buffer. A strobe timer then moves the byte into an output register, places it on the data bus and pulses an active-low write strobe. The timing comes from one 16-bit setting. The low byte sets the half-period of the strobe in clock cycles. The high byte sets how many strobe edges one timer run spans.

Two sticky flags report progress. The buffer-empty flag shows when the staging buffer can take a new byte. The done flag shows that a timer run has finished. Both flags are cleared by writing one. When the host keeps the buffer topped up, strobes follow one another with no idle gap. The back-pressure rule is simple: `in_ready` is high only while the block is enabled and the buffer-empty flag is set. A byte is taken on every clock edge where `in_valid` and `in_ready` are both high.

The timer starts only while the buffer holds unsent data, so it is triggered by the empty flag being low. After the block is enabled, the empty flag is set. As a result, enabling the block with nothing to send never produces a strobe.

Top module: `pbus_wr_engine`

## Requirements
- R1: After reset, `wr_n` is 1, `bus_data` is 0, `buf_empty` is 1, `done_flag` is 0 and `in_ready` is 0.
- R2: `in_ready` equals `enable` AND `buf_empty`. A byte is accepted on a clock edge where `in_valid` and `in_ready` are both high. While `enable` is low, `buf_empty` is held at 1 and no byte is accepted.
- R3: After `enable` rises, and until a byte is accepted or `empty_clr` is pulsed, `wr_n` stays 1.
- R4: When an idle, enabled block accepts a byte, `wr_n` goes to 0 in the cycle right after the accepting edge. It stays 0 for L+1 cycles and then stays 1 for L+1 cycles, where L = `timing_cfg[7:0]`.
- R5: `bus_data` shows the new byte from the cycle in which `wr_n` falls. It holds that byte for every cycle `wr_n` is 0 and for the cycle in which `wr_n` returns to 1.
- R6: One timer run spans H+1 half-periods, where H = `timing_cfg[15:8]` (odd). That gives (H+1)/2 strobes. Each strobe after the first loads the buffered byte if there is one, and otherwise repeats the current byte.
- R7: If a byte is waiting when a run ends on its high half, the next strobe begins at once. In that case `wr_n` is 1 for exactly L+1 cycles between the two strobes.
- R8: `done_flag` is set in the cycle after a run ends. A 1 on `done_clr` clears it, and a 0 leaves it unchanged. If a run ends in the same cycle that `done_clr` is 1, the set wins.
- R9: `buf_empty` clears when a byte is accepted and the buffer does not pass it on in the same cycle. It sets when the buffer contents move to the output. A 1 on `empty_clr` while the flag is set clears it, and the last stored byte is then sent again. With no write and no `empty_clr`, no strobe occurs.
- R10: When `enable` is low at a clock edge, `wr_n` is 1 after that edge and the timer stops. `bus_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Engine enable; low stops the strobe timer |
| timing_cfg | input | 16 | [7:0] half-period minus one, [15:8] edges per run minus one |
| in_valid | input | 1 | Host byte offered |
| in_data | input | 8 | Host byte |
| in_ready | output | 1 | Buffer can take a byte |
| empty_clr | input | 1 | Write-one-to-clear for the buffer-empty flag |
| buf_empty | output | 1 | Buffer-empty flag |
| done_clr | input | 1 | Write-one-to-clear for the done flag |
| done_flag | output | 1 | Timer run finished |
| wr_n | output | 1 | Active-low write strobe |
| bus_data | output | 8 | Parallel data bus |

## Verification
Two events can land on the same clock edge.

The first pair is the end of a timer run, which sets the done flag, and a host clear of that flag. The bench holds `done_clr` high across a whole transfer. The design is judged correct only if the flag is seen high for a cycle after the run ends.

The second pair is a byte arriving and the buffer handing a byte to the output register. A burst keeps the buffer refilled so that every run ends with data waiting. The gap between strobes is then measured, and the byte order on the bus is checked.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
  // Level of the internal shift clock; DRIVE is the strobe-active half.
  typedef enum logic {
    LINE_REST  = 1'b0,
    LINE_DRIVE = 1'b1
  } line_phase_e;
endpackage

// File: rtl/pbw_txbuf.sv
module pbw_txbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              empty_clr,
  input  logic              take,
  output logic              in_ready,
  output logic              empty,
  output logic              pending,
  output logic [DATA_W-1:0] pend_data
);
  logic [DATA_W-1:0] store_q;
  logic              empty_q;
  logic              fire;

  assign in_ready  = enable && empty_q;
  assign fire      = in_valid && in_ready;
  // A byte arriving this cycle counts as pending so a run can chain onto it.
  assign pending   = !empty_q || fire;
  assign pend_data = empty_q ? in_data : store_q;
  assign empty     = empty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      store_q <= '0;
    end else begin
      if (fire) store_q <= in_data;
      if (!enable)        empty_q <= 1'b1;
      else if (take)      empty_q <= 1'b1;
      else if (fire)      empty_q <= 1'b0;
      else if (empty_clr) empty_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pbw_timer.sv
module pbw_timer
  import pbw_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             pending,
  input  logic [CNT_W-1:0] half_lim,
  input  logic [CNT_W-1:0] edge_lim,
  output line_phase_e      phase,
  output logic             load,
  output logic             run_end
);
  logic             running_q;
  line_phase_e      phase_q;
  logic [CNT_W-1:0] half_q;
  logic [CNT_W-1:0] edge_q;
  logic             expire, last;
  logic             start_idle, restart, mid_load;

  assign expire     = running_q && (half_q == half_lim);
  assign last       = expire && (edge_q == edge_lim);
  assign start_idle = enable && !running_q && pending;
  assign restart    = enable && last && (phase_q == LINE_REST) && pending;
  assign mid_load   = enable && expire && !last && (phase_q == LINE_REST) && pending;
  assign load       = start_idle || restart || mid_load;
  assign run_end    = enable && last;
  assign phase      = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      phase_q   <= LINE_REST;
      half_q    <= '0;
      edge_q    <= '0;
    end else if (!enable) begin
      running_q <= 1'b0;
      phase_q   <= LINE_REST;
      half_q    <= '0;
      edge_q    <= '0;
    end else if (!running_q) begin
      if (pending) begin
        running_q <= 1'b1;
        phase_q   <= LINE_DRIVE;
        half_q    <= '0;
        edge_q    <= '0;
      end
    end else if (expire) begin
      half_q <= '0;
      if (last) begin
        edge_q <= '0;
        if (restart) begin
          phase_q <= LINE_DRIVE;
        end else begin
          running_q <= 1'b0;
          phase_q   <= LINE_REST;
        end
      end else begin
        edge_q  <= edge_q + 1'b1;
        phase_q <= (phase_q == LINE_DRIVE) ? LINE_REST : LINE_DRIVE;
      end
    end else begin
      half_q <= half_q + 1'b1;
    end
  end
endmodule

// File: rtl/pbw_outreg.sv
module pbw_outreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/pbus_wr_engine.sv
module pbus_wr_engine
  import pbw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [2*CNT_W-1:0]  timing_cfg,
  input  logic                in_valid,
  input  logic [DATA_W-1:0]   in_data,
  output logic                in_ready,
  input  logic                empty_clr,
  output logic                buf_empty,
  input  logic                done_clr,
  output logic                done_flag,
  output logic                wr_n,
  output logic [DATA_W-1:0]   bus_data
);
  localparam int CFG_W = 2 * CNT_W;

  logic              pending, load, run_end;
  logic [DATA_W-1:0] pend_data;
  line_phase_e       phase;
  logic [CNT_W-1:0]  half_lim, edge_lim;
  logic              done_q;

  assign half_lim = timing_cfg[CNT_W-1:0];
  assign edge_lim = timing_cfg[CFG_W-1:CNT_W];

  pbw_txbuf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .in_valid(in_valid), .in_data(in_data), .empty_clr(empty_clr),
    .take(load), .in_ready(in_ready), .empty(buf_empty),
    .pending(pending), .pend_data(pend_data)
  );

  pbw_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pending(pending),
    .half_lim(half_lim), .edge_lim(edge_lim),
    .phase(phase), .load(load), .run_end(run_end)
  );

  pbw_outreg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .din(pend_data), .dout(bus_data)
  );

  // Run completion beats a host clear arriving on the same edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_q <= 1'b0;
    else if (run_end)  done_q <= 1'b1;
    else if (done_clr) done_q <= 1'b0;
  end

  assign done_flag = done_q;
  assign wr_n      = (phase != LINE_DRIVE);
endmodule

// File: rtl/pbw_checker.sv
module pbw_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              in_valid,
  input logic              in_ready,
  input logic              empty_clr,
  input logic              buf_empty,
  input logic              done_clr,
  input logic              done_flag,
  input logic              wr_n,
  input logic [DATA_W-1:0] bus_data
);
  assert_strobe_off_when_disabled_R10: assert property (
    @(posedge clk) disable iff (!rst_n) !enable |=> wr_n);

  assert_data_steady_low_R5: assert property (
    @(posedge clk) disable iff (!rst_n) (!wr_n && !$past(wr_n)) |-> $stable(bus_data));

  assert_data_steady_rise_R5: assert property (
    @(posedge clk) disable iff (!rst_n) $rose(wr_n) |-> $stable(bus_data));

  assert_ready_rule_R2: assert property (
    @(posedge clk) disable iff (!rst_n) in_ready |-> (buf_empty && enable));

  assert_done_sticky_R8: assert property (
    @(posedge clk) disable iff (!rst_n) (done_flag && !done_clr) |=> done_flag);

  assert_no_idle_pulse_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
      ($rose(enable) && !in_valid && !empty_clr) |=> wr_n);
endmodule

bind pbus_wr_engine pbw_checker #(.DATA_W(DATA_W)) u_pbw_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .in_valid(in_valid),
  .in_ready(in_ready), .empty_clr(empty_clr), .buf_empty(buf_empty),
  .done_clr(done_clr), .done_flag(done_flag), .wr_n(wr_n), .bus_data(bus_data)
);

// File: tb/tb_pbus_wr_engine.sv
module tb_pbus_wr_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic [15:0] timing_cfg;
  logic        in_valid;
  logic [7:0]  in_data;
  logic        in_ready;
  logic        empty_clr;
  logic        buf_empty;
  logic        done_clr;
  logic        done_flag;
  logic        wr_n;
  logic [7:0]  bus_data;

  always #10 clk = ~clk;

  pbus_wr_engine dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .timing_cfg(timing_cfg),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .empty_clr(empty_clr), .buf_empty(buf_empty), .done_clr(done_clr),
    .done_flag(done_flag), .wr_n(wr_n), .bus_data(bus_data)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // Strobe monitor, sampled on the falling clock edge.
  int         falls = 0;
  logic [7:0] fdat [0:63];
  int         flow [0:63];
  int         fgap [0:63];
  int         lowlen = 0;
  int         hilen  = 0;
  bit         prev_wr = 1'b1;
  logic [7:0] held = '0;
  int         stab_err = 0;
  int         done_seen = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_wr && !wr_n) begin
        if (falls < 64) begin
          fdat[falls] = bus_data;
          fgap[falls] = hilen;
        end
        falls  = falls + 1;
        held   = bus_data;
        lowlen = 1;
      end else if (!wr_n) begin
        lowlen = lowlen + 1;
        if (bus_data !== held) stab_err = stab_err + 1;
      end else if (!prev_wr && wr_n) begin
        if (falls > 0 && falls <= 64) flow[falls-1] = lowlen;
        if (bus_data !== held) stab_err = stab_err + 1;
        hilen = 1;
      end else begin
        hilen = hilen + 1;
      end
      if (done_flag) done_seen = done_seen + 1;
      prev_wr = wr_n;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "wr_n", wr_n, 1);
    chk("R1", "bus_data", bus_data, 0);
    chk("R1", "buf_empty", buf_empty, 1);
    chk("R1", "done_flag", done_flag, 0);
    chk("R1", "in_ready", in_ready, 0);
  endtask

  task automatic t_idle_enable();
    int f0 = falls;
    enable = 1'b1;
    waitn(20);
    chk("R3", "no strobe after enable", falls - f0, 0);
    chk("R2", "in_ready when enabled and empty", in_ready, 1);
  endtask

  task automatic t_single();
    int f0 = falls;
    push(8'hA5);
    in_valid = 1'b0;
    chk("R4", "wr_n low right after accept", wr_n, 0);
    waitn(10);
    chk("R4", "one strobe", falls - f0, 1);
    chk("R5", "byte on bus", fdat[f0], 8'hA5);
    chk("R4", "low width", flow[f0], 3);
    chk("R8", "done set after run", done_flag, 1);
  endtask

  task automatic t_done_w1c();
    waitn(5);
    chk("R8", "done holds without clear", done_flag, 1);
    done_clr = 1'b1;
    waitn(1);
    done_clr = 1'b0;
    chk("R8", "done cleared by one", done_flag, 0);
  endtask

  task automatic t_burst();
    int f0 = falls;
    push(8'h11);
    push(8'h22);
    chk("R9", "write clears empty flag", buf_empty, 0);
    push(8'h33);
    push(8'h44);
    in_valid = 1'b0;
    waitn(30);
    chk("R7", "burst strobes", falls - f0, 4);
    chk("R7", "burst byte 0", fdat[f0], 8'h11);
    chk("R7", "burst byte 1", fdat[f0+1], 8'h22);
    chk("R7", "burst byte 2", fdat[f0+2], 8'h33);
    chk("R7", "burst byte 3", fdat[f0+3], 8'h44);
    for (int i = 1; i < 4; i++) chk("R7", "gap between strobes", fgap[f0+i], 3);
    for (int i = 0; i < 4; i++) chk("R4", "burst low width", flow[f0+i], 3);
  endtask

  task automatic t_coincide();
    int d0 = done_seen;
    done_clr = 1'b1;
    push(8'h5A);
    in_valid = 1'b0;
    waitn(12);
    done_clr = 1'b0;
    chk("R8", "set beats clear on same edge", (done_seen > d0) ? 1 : 0, 1);
    chk("R8", "held clear removes flag afterwards", done_flag, 0);
  endtask

  task automatic t_empty_clr();
    int f0 = falls;
    waitn(10);
    chk("R9", "no strobe without write", falls - f0, 0);
    empty_clr = 1'b1;
    waitn(1);
    empty_clr = 1'b0;
    waitn(10);
    chk("R9", "empty_clr resends", falls - f0, 1);
    chk("R9", "resent byte", fdat[f0], 8'h5A);
  endtask

  task automatic t_multibeat();
    int f0;
    waitn(1);
    enable = 1'b0;
    waitn(1);
    timing_cfg = 16'h0302;
    enable = 1'b1;
    waitn(2);
    f0 = falls;
    push(8'h81);
    in_valid = 1'b0;
    waitn(20);
    chk("R6", "two strobes per run", falls - f0, 2);
    chk("R6", "first beat byte", fdat[f0], 8'h81);
    chk("R6", "repeat beat byte", fdat[f0+1], 8'h81);
    chk("R6", "gap inside run", fgap[f0+1], 3);
    f0 = falls;
    push(8'h12);
    push(8'h34);
    in_valid = 1'b0;
    waitn(20);
    chk("R6", "strobes with refill", falls - f0, 2);
    chk("R6", "refill first", fdat[f0], 8'h12);
    chk("R6", "refill second", fdat[f0+1], 8'h34);
  endtask

  task automatic t_disable();
    int f0;
    enable = 1'b0;
    waitn(1);
    timing_cfg = 16'h0108;
    enable = 1'b1;
    waitn(2);
    push(8'hC3);
    in_valid = 1'b0;
    waitn(3);
    chk("R10", "still low before disable", wr_n, 0);
    enable = 1'b0;
    waitn(1);
    chk("R10", "wr_n high after disable", wr_n, 1);
    chk("R10", "bus keeps byte", bus_data, 8'hC3);
    chk("R2", "in_ready low when disabled", in_ready, 0);
    chk("R2", "empty held when disabled", buf_empty, 1);
    f0 = falls;
    in_valid = 1'b1;
    in_data  = 8'h99;
    waitn(5);
    in_valid = 1'b0;
    chk("R2", "disabled writes refused", falls - f0, 0);
    enable = 1'b1;
    waitn(25);
    chk("R3", "no strobe on re-enable", falls - f0, 0);
    chk("R10", "bus unchanged after re-enable", bus_data, 8'hC3);
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b0; timing_cfg = 16'h0102;
    in_valid = 1'b0; in_data = '0; empty_clr = 1'b0; done_clr = 1'b0;
    waitn(3);
    rst_n = 1'b1;
    waitn(1);
    t_reset();
    t_idle_enable();
    t_single();
    t_done_w1c();
    t_burst();
    t_coincide();
    t_empty_clr();
    t_multibeat();
    t_disable();
    chk("R5", "data stable while strobe low", stab_err, 0);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog run did not end actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule